// File: doc/BRIEF.md
# Per-Source Interrupt Routing Matrix

This block sits behind the source conditioning stage of an interrupt controller. It takes a 32-bit vector of pending, already masked interrupt sources and steers each active source to the interrupt lines of up to four processors. Every processor receives six ordinary interrupt lines, one non-maskable line and one yield line.

Routing is set per source by two registers written over a simple 32-bit bus. The pin map register picks the destination class and an ordinary pin number. The processor bitmap register picks which processors receive the source, so one source can be broadcast to several processors at once. The outputs for a processor are the OR of every pending source routed to it. They are registered, so an output follows the pending vector one clock later.

Bus reads are combinational from the current register contents. Writes take effect on the clock edge at which the write enable is sampled high.

Top module: `irq_route_matrix`

## Requirements
- R1: The pin map register of source n is at byte address 0x500 + 4*n. A write stores bit 31 (ordinary flag), bit 30 (non-maskable flag), bit 29 (yield flag) and bits 5:0 (pin number). A read returns those bits in the same positions and zero in bits 28:6.
- R2: The processor bitmap of source n is at byte address 0x2000 + 32*n. Bit p selects processor p, for p from 0 to 3. A read returns the stored bits and zero in bits 31:4.
- R3: After reset every map register reads zero. Every output is low, even while sources are pending.
- R4: A pending source with only the ordinary flag set and pin number k below 6 drives ordinary line k of each processor selected in its bitmap. Processor p's line k is bit p*6 + k of `intLines`. A source with no flag set drives nothing.
- R5: When the non-maskable flag is set, the source drives only the non-maskable line of its selected processors, whatever the other two flags hold.
- R6: When the yield flag is set and the non-maskable flag is clear, the source drives only the yield line, even if the ordinary flag is set.
- R7: An ordinary-routed source whose pin number is 6 or more drives no line.
- R8: Each output line is the OR over all pending sources that route to it. One source reaches every processor whose bitmap bit is set.
- R9: Outputs at a clock edge reflect the pending vector and map contents sampled at that edge. The latency is one cycle. A map write at the same edge affects the outputs only from the next edge.
- R10: A write to any address outside the two register arrays changes no map state, and a read of it returns zero. This covers the unused words within each 32-byte bitmap stride.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pendVec | input | 32 | Masked pending sources, one bit per source |
| busWe | input | 1 | Bus write enable |
| busAddr | input | 14 | Bus byte address |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Bus read data for busAddr, combinational |
| intLines | output | 24 | Ordinary lines, processor p's line k at bit p*6+k |
| nmiLines | output | 4 | Non-maskable line per processor |
| yieldLines | output | 4 | Yield line per processor |

## Verification
A map write and a routing decision can fall on the same clock edge. The design must route with the old mapping at that edge and with the new one from the next edge. The bench provokes this by holding a source pending while it rewrites that source's pin map and bitmap, and by rewriting flags while other sources stay active. A behavioural model steps once per edge, computing its outputs before it applies the write. Every cycle is compared against that model, so an ordering slip in either direction shows up as a miscompare in the cycle of the write.

// File: rtl/rmx_pkg.sv
package rmx_pkg;
  localparam int IDX_W = 8;
  localparam logic [31:0] PIN_BASE = 32'h0000_0500;
  localparam logic [31:0] CPU_BASE = 32'h0000_2000;
  localparam int PIN_STRIDE = 4;
  localparam int CPU_STRIDE = 32;
  localparam int ORD_BIT = 31;
  localparam int NMI_BIT = 30;
  localparam int YLD_BIT = 29;
  localparam int PIN_FIELD_W = 6;

  typedef struct packed {
    logic pinWr;
    logic cpuWr;
    logic rdPin;
    logic rdCpu;
    logic [IDX_W-1:0] srcIdx;
  } rmxStrobe_t;
endpackage

// File: rtl/rmx_ctrl.sv
module rmx_ctrl
  import rmx_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 14
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output rmxStrobe_t        strb
);
  localparam logic [31:0] PIN_END = PIN_BASE + 32'(PIN_STRIDE * NUM_SRC);
  localparam logic [31:0] CPU_END = CPU_BASE + 32'(CPU_STRIDE * NUM_SRC);

  logic [31:0] fullAddr;
  logic [31:0] pinOff;
  logic [31:0] cpuOff;
  logic inPin;
  logic inCpu;

  always_comb begin
    fullAddr = 32'(busAddr);
    pinOff   = fullAddr - PIN_BASE;
    cpuOff   = fullAddr - CPU_BASE;
    inPin    = (fullAddr >= PIN_BASE) && (fullAddr < PIN_END) && (pinOff[1:0] == 2'b00);
    inCpu    = (fullAddr >= CPU_BASE) && (fullAddr < CPU_END) && (cpuOff[4:0] == 5'b0);
    strb.pinWr  = busWe && inPin;
    strb.cpuWr  = busWe && inCpu;
    strb.rdPin  = inPin;
    strb.rdCpu  = inCpu;
    if (inPin)      strb.srcIdx = IDX_W'(pinOff >> 2);
    else if (inCpu) strb.srcIdx = IDX_W'(cpuOff >> 5);
    else            strb.srcIdx = '0;
  end
endmodule

// File: rtl/rmx_datapath.sv
module rmx_datapath
  import rmx_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CPU  = 4,
  parameter int NUM_PINS = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  rmxStrobe_t                   strb,
  input  logic [31:0]                  wrData,
  input  logic [NUM_SRC-1:0]           pendVec,
  output logic [31:0]                  rdData,
  output logic [NUM_CPU*NUM_PINS-1:0]  intLines,
  output logic [NUM_CPU-1:0]           nmiLines,
  output logic [NUM_CPU-1:0]           yieldLines
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  // flagQ[2]=ordinary, [1]=non-maskable, [0]=yield
  logic [2:0]             flagQ [NUM_SRC];
  logic [PIN_FIELD_W-1:0] pinQ  [NUM_SRC];
  logic [NUM_CPU-1:0]     cpuQ  [NUM_SRC];
  logic [SRC_W-1:0]       idx;

  assign idx = strb.srcIdx[SRC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NUM_SRC; n++) begin
        flagQ[n] <= '0;
        pinQ[n]  <= '0;
        cpuQ[n]  <= '0;
      end
    end else begin
      if (strb.pinWr) begin
        flagQ[idx] <= {wrData[ORD_BIT], wrData[NMI_BIT], wrData[YLD_BIT]};
        pinQ[idx]  <= wrData[PIN_FIELD_W-1:0];
      end
      if (strb.cpuWr) cpuQ[idx] <= wrData[NUM_CPU-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdPin) begin
      rdData[ORD_BIT] = flagQ[idx][2];
      rdData[NMI_BIT] = flagQ[idx][1];
      rdData[YLD_BIT] = flagQ[idx][0];
      rdData[PIN_FIELD_W-1:0] = pinQ[idx];
    end else if (strb.rdCpu) begin
      rdData[NUM_CPU-1:0] = cpuQ[idx];
    end
  end

  for (genvar gp = 0; gp < NUM_CPU; gp++) begin : g_cpu
    logic [NUM_PINS-1:0] nxtInt;
    logic nxtNmi;
    logic nxtYld;
    logic [NUM_PINS-1:0] intQ;
    logic nmiQ;
    logic yldQ;

    always_comb begin
      nxtInt = '0;
      nxtNmi = 1'b0;
      nxtYld = 1'b0;
      for (int n = 0; n < NUM_SRC; n++) begin
        if (pendVec[n] && cpuQ[n][gp]) begin
          if (flagQ[n][1])      nxtNmi = 1'b1;
          else if (flagQ[n][0]) nxtYld = 1'b1;
          else if (flagQ[n][2]) begin
            for (int k = 0; k < NUM_PINS; k++)
              if (pinQ[n] == PIN_FIELD_W'(k)) nxtInt[k] = 1'b1;
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        intQ <= '0;
        nmiQ <= 1'b0;
        yldQ <= 1'b0;
      end else begin
        intQ <= nxtInt;
        nmiQ <= nxtNmi;
        yldQ <= nxtYld;
      end
    end

    assign intLines[gp*NUM_PINS +: NUM_PINS] = intQ;
    assign nmiLines[gp]   = nmiQ;
    assign yieldLines[gp] = yldQ;
  end

  p_reset_clear_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (intLines == '0 && nmiLines == '0 && yieldLines == '0));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(pendVec) == '0) |-> (intLines == '0 && nmiLines == '0 && yieldLines == '0));

  p_pin_store_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(strb.pinWr) && !$past(rst) && strb.rdPin && strb.srcIdx == $past(strb.srcIdx))
      |-> (rdData[31:29] == $past(wrData[31:29]) && rdData[5:0] == $past(wrData[5:0])
           && rdData[28:6] == '0));

  p_cpu_store_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(strb.cpuWr) && !$past(rst) && strb.rdCpu && strb.srcIdx == $past(strb.srcIdx))
      |-> (rdData[NUM_CPU-1:0] == $past(wrData[NUM_CPU-1:0]) && rdData[31:NUM_CPU] == '0));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (!strb.rdPin && !strb.rdCpu) |-> (rdData == '0));
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import rmx_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CPU  = 4,
  parameter int NUM_PINS = 6,
  parameter int ADDR_W   = 14
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_SRC-1:0]           pendVec,
  input  logic                         busWe,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [31:0]                  busWdata,
  output logic [31:0]                  busRdata,
  output logic [NUM_CPU*NUM_PINS-1:0]  intLines,
  output logic [NUM_CPU-1:0]           nmiLines,
  output logic [NUM_CPU-1:0]           yieldLines
);
  rmxStrobe_t strb;

  rmx_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .busWe   (busWe),
    .busAddr (busAddr),
    .strb    (strb)
  );

  rmx_datapath #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .NUM_PINS(NUM_PINS)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .wrData     (busWdata),
    .pendVec    (pendVec),
    .rdData     (busRdata),
    .intLines   (intLines),
    .nmiLines   (nmiLines),
    .yieldLines (yieldLines)
  );
endmodule

// File: tb/sim_irq_route_matrix.sv
module sim_irq_route_matrix;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] pendVec = '0;
  logic busWe = 1'b0;
  logic [13:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [23:0] intLines;
  logic [3:0]  nmiLines;
  logic [3:0]  yieldLines;

  irq_route_matrix u0 (
    .clk(clk), .rst(rst), .pendVec(pendVec), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .intLines(intLines),
    .nmiLines(nmiLines), .yieldLines(yieldLines)
  );

  always #5 clk = ~clk;

  integer vectors = 0;
  integer fails = 0;
  integer cycles = 0;
  bit done = 0;
  string curReq = "R3";

  logic [31:0] pm [32];
  logic [31:0] cm [32];
  logic [23:0] expInt = '0;
  logic [3:0]  expNmi = '0;
  logic [3:0]  expYld = '0;

  // Behavioural reference: outputs from pre-edge state, then apply the write.
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int n = 0; n < 32; n++) begin pm[n] = '0; cm[n] = '0; end
      expInt = '0; expNmi = '0; expYld = '0;
    end else begin
      expInt = '0; expNmi = '0; expYld = '0;
      for (int n = 0; n < 32; n++)
        for (int p = 0; p < 4; p++)
          if (pendVec[n] && cm[n][p]) begin
            if (pm[n][30]) expNmi[p] = 1'b1;
            else if (pm[n][29]) expYld[p] = 1'b1;
            else if (pm[n][31] && (pm[n] & 32'h3f) < 6) expInt[p*6 + int'(pm[n] & 32'h3f)] = 1'b1;
          end
      if (busWe) begin
        int a;
        a = int'(busAddr);
        if (a >= 'h500 && a < 'h500 + 128 && a % 4 == 0) pm[(a - 'h500) / 4] = busWdata & 32'he000_003f;
        if (a >= 'h2000 && a < 'h2000 + 1024 && a % 32 == 0) cm[(a - 'h2000) / 32] = busWdata & 32'hf;
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 0 && !done) begin
      vectors++;
      if (intLines !== expInt || nmiLines !== expNmi || yieldLines !== expYld) begin
        fails++;
        $display("FAIL %s cycle %0d: got int=%h nmi=%h yld=%h expected int=%h nmi=%h yld=%h",
                 curReq, cycles, intLines, nmiLines, yieldLines, expInt, expNmi, expYld);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 50000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL R9 watchdog: cycles %0d expected below 50000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = 14'(a); busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdChk(input int a, input logic [31:0] e, input string req);
    @(negedge clk);
    busWe = 1'b0; busAddr = 14'(a);
    #1;
    vectors++;
    if (busRdata !== e) begin
      fails++;
      $display("FAIL %s read %h: got %h expected %h", req, a, busRdata, e);
    end
  endtask

  task automatic setPend(input logic [31:0] v, input int hold);
    @(negedge clk);
    pendVec = v;
    repeat (hold) @(negedge clk);
  endtask

  initial begin
    pendVec = 32'hffff_ffff;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    curReq = "R3";
    repeat (3) @(negedge clk);
    rdChk('h500, 32'h0, "R3");
    rdChk('h2000 + 32*31, 32'h0, "R3");
    pendVec = '0;

    curReq = "R1";
    wr('h500 + 4*3, 32'hffff_ffff);
    rdChk('h500 + 4*3, 32'he000_003f, "R1");
    wr('h500 + 4*7, 32'h8000_0002);
    rdChk('h500 + 4*7, 32'h8000_0002, "R1");

    curReq = "R2";
    wr('h2000 + 32*5, 32'hffff_ffff);
    rdChk('h2000 + 32*5, 32'h0000_000f, "R2");

    curReq = "R10";
    wr('h2004, 32'hffff_ffff);
    rdChk('h2004, 32'h0, "R10");
    wr('h480, 32'hffff_ffff);
    rdChk('h480, 32'h0, "R10");
    wr('h502, 32'hffff_ffff);
    rdChk('h500, 32'h0, "R10");
    rdChk('h2000, 32'h0, "R10");

    curReq = "R4";
    wr('h500 + 4*2, 32'h8000_0003);
    wr('h2000 + 32*2, 32'h5);
    setPend(32'h4, 3);
    wr('h500 + 4*9, 32'h0000_0001);
    wr('h2000 + 32*9, 32'hf);
    setPend(32'h200, 3);

    curReq = "R5";
    wr('h500 + 4*4, 32'he000_0001);
    wr('h2000 + 32*4, 32'h2);
    setPend(32'h10, 3);

    curReq = "R6";
    wr('h500 + 4*6, 32'ha000_0002);
    wr('h2000 + 32*6, 32'h8);
    setPend(32'h40, 3);

    curReq = "R7";
    wr('h500 + 4*8, 32'h8000_0006);
    wr('h2000 + 32*8, 32'hf);
    wr('h500 + 4*10, 32'h8000_003f);
    wr('h2000 + 32*10, 32'hf);
    setPend(32'h500, 3);

    curReq = "R8";
    wr('h500 + 4*11, 32'h8000_0003);
    wr('h2000 + 32*11, 32'ha);
    setPend(32'h0000_0854, 3);
    for (int i = 0; i < 12; i++) begin
      wr('h500 + 4*(12+i), {3'($urandom), 23'h0, 6'($urandom % 8)});
      wr('h2000 + 32*(12+i), 32'($urandom));
    end
    for (int i = 0; i < 200; i++) setPend($urandom, 1);

    curReq = "R9";
    for (int i = 0; i < 40; i++) setPend((i % 2 == 0) ? 32'h0fff_fffc : 32'h0000_0000, 0);
    setPend(32'h4, 0);
    @(negedge clk);
    busWe = 1'b1; busAddr = 14'('h500 + 4*2); busWdata = 32'h4000_0000;
    @(negedge clk);
    busWe = 1'b1; busAddr = 14'('h2000 + 32*2); busWdata = 32'h9;
    @(negedge clk);
    busWe = 1'b1; busAddr = 14'('h500 + 4*2); busWdata = 32'h8000_0005;
    @(negedge clk);
    busWe = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      pendVec = $urandom;
      busWe = 1'b1;
      busAddr = ($urandom % 2 == 0) ? 14'('h500 + 4*($urandom % 32)) : 14'('h2000 + 32*($urandom % 32));
      busWdata = $urandom;
    end
    @(negedge clk);
    busWe = 1'b0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule